// File: doc/BRIEF.md
# PRBS Pattern Verifier

This block checks a received parallel data stream against a pseudo-random binary sequence. The sequence is chosen by a select input: a seven-stage or a thirty-one-stage linear feedback register. Each data word is handled with its most significant bit first. The local generator steps once for every bit of the word.

After a clear, the verifier synchronises itself to the stream. While aligning, it fills its generator history from the received bits. It counts the valid words that match the prediction and must see a run of them in a row. It then lets the generator run freely for a qualification pass, and every word of that pass must also match. When the pass is complete, the done flag goes high and stays high until the next clear. While done is high, each received word that differs from the prediction gives a one-cycle error pulse. A word gives one pulse however many of its bits are wrong. Words that arrive while the valid strobe is low are ignored.

Top module: `prbs_verifier`

## Requirements
- R1: While reset is high, and on the first cycle after it, `done_o` and `err_o` are both low.
- R2: `poly_sel_i` = 0 selects x^7+x^6+1 and `poly_sel_i` = 1 selects x^31+x^28+1. In both cases each word bit equals the XOR of the stream bits 7 and 6 positions earlier (or 31 and 28 positions earlier), and bits are taken from the MSB down to the LSB. After changing the select, software applies a clear.
- R3: After a clear, the first valid word only seeds the generator history. Alignment then needs LOCK_WORDS consecutive valid words that match the prediction made from that seeded history.
- R4: After alignment, a qualification pass of matching words follows: ceil(127/DATA_W) words for the 7-stage sequence and PASS31_WORDS words for the 31-stage one. A mismatch during this pass sends the block back to alignment. `done_o` rises in the cycle after the edge that samples the last word of the pass.
- R5: `err_o` is never high unless `done_o` is high. It goes high for one cycle, in the cycle after the edge that samples a valid word differing from the prediction.
- R6: An erroneous word gives exactly one error cycle, whether one bit or all of its bits are wrong.
- R7: Once aligned, the generator runs freely. A corrupted word therefore does not cause an error on the correct words that follow it.
- R8: A word offered with `valid_i` low does not advance the generator and raises no error, and `done_o` holds its value.
- R9: A clear forces `done_o` and `err_o` low in the next cycle and takes priority over a valid word offered on the same edge. The full alignment sequence then has to be repeated.
- R10: A history of all zeros never counts as a match, so a stream of all-zero words never aligns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| data_i | input | DATA_W | Received data word, MSB first |
| valid_i | input | 1 | Word strobe |
| poly_sel_i | input | 1 | 0: 7-stage sequence, 1: 31-stage sequence |
| clr_i | input | 1 | Restart alignment and drop done |
| done_o | output | 1 | Aligned and first pass complete |
| err_o | output | 1 | One-cycle pulse per mismatching word |

## Verification
A clear and an erroneous valid word can meet on the same edge. On that edge the error report and the clear compete for the outputs. The bench locks the verifier and then offers a corrupted word with the clear high. It expects no error pulse and `done_o` low in the next cycle, then a complete new alignment before done returns. The bench also runs a random mix of clean and corrupted words, with mismatch masks of varied bit counts. It checks that each corrupted word produces one pulse and that the clean words after it stay quiet.

// File: rtl/prbs_verifier_pkg.sv
package prbs_verifier_pkg;

  localparam int HIST_W = 31;

  typedef enum logic [1:0] {
    ST_ALIGN  = 2'd0,
    ST_QUAL   = 2'd1,
    ST_LOCKED = 2'd2
  } vstate_t;

  // Next sequence bit from history; h[k] holds the bit received k+1 steps ago.
  function automatic logic next_bit(input logic [HIST_W-1:0] h, input logic long_poly);
    return long_poly ? (h[30] ^ h[27]) : (h[6] ^ h[5]);
  endfunction

endpackage

// File: rtl/prbs_word_predict.sv
module prbs_word_predict
  import prbs_verifier_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [HIST_W-1:0] hist_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              reseed_i,
  output logic [DATA_W-1:0] expect_o,
  output logic [HIST_W-1:0] hist_o
);

  logic [HIST_W-1:0] h;
  logic              b;

  always_comb begin
    h        = hist_i;
    b        = 1'b0;
    expect_o = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      b           = next_bit(h, sel_i);
      expect_o[i] = b;
      h           = {h[HIST_W-2:0], (reseed_i ? data_i[i] : b)};
    end
    hist_o = h;
  end

endmodule

// File: rtl/prbs_lock_ctrl.sv
module prbs_lock_ctrl
  import prbs_verifier_pkg::*;
#(
  parameter int LOCK_WORDS = 4,
  parameter int QUAL7      = 4,
  parameter int QUAL31     = 64
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic valid_i,
  input  logic sel_i,
  input  logic match_i,
  input  logic seeded_i,
  output logic reseed_o,
  output logic done_o
);

  localparam int QMAX = (QUAL7 > QUAL31) ? QUAL7 : QUAL31;
  localparam int MW   = $clog2(LOCK_WORDS + 1);
  localparam int QW   = $clog2(QMAX + 1);

  vstate_t       st_q;
  logic [MW-1:0] mcnt_q;
  logic [QW-1:0] qcnt_q;
  logic [QW-1:0] qlast;

  assign qlast    = sel_i ? QW'(QUAL31 - 1) : QW'(QUAL7 - 1);
  assign reseed_o = (st_q == ST_ALIGN);

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      st_q   <= ST_ALIGN;
      mcnt_q <= '0;
      qcnt_q <= '0;
      done_o <= 1'b0;
    end else if (valid_i) begin
      case (st_q)
        ST_ALIGN: begin
          if (match_i && seeded_i) begin
            if (mcnt_q == MW'(LOCK_WORDS - 1)) begin
              st_q   <= ST_QUAL;
              mcnt_q <= '0;
              qcnt_q <= '0;
            end else begin
              mcnt_q <= mcnt_q + 1'b1;
            end
          end else begin
            mcnt_q <= '0;
          end
        end
        ST_QUAL: begin
          if (!match_i) begin
            st_q   <= ST_ALIGN;
            mcnt_q <= '0;
          end else if (qcnt_q == qlast) begin
            st_q   <= ST_LOCKED;
            done_o <= 1'b1;
          end else begin
            qcnt_q <= qcnt_q + 1'b1;
          end
        end
        default: st_q <= ST_LOCKED;
      endcase
    end
  end

endmodule

// File: rtl/prbs_verifier.sv
module prbs_verifier
  import prbs_verifier_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int LOCK_WORDS   = 4,
  parameter int PASS31_WORDS = 64
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              poly_sel_i,
  input  logic              clr_i,
  output logic              done_o,
  output logic              err_o
);

  localparam int PASS7_WORDS = (127 + DATA_W - 1) / DATA_W;

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;
  logic [DATA_W-1:0] expect_w;
  logic              reseed;
  logic              match;
  logic              seeded;
  logic              locked;

  prbs_word_predict #(.DATA_W(DATA_W)) u_pred (
    .hist_i   (hist_q),
    .sel_i    (poly_sel_i),
    .data_i   (data_i),
    .reseed_i (reseed),
    .expect_o (expect_w),
    .hist_o   (hist_d)
  );

  assign match  = (expect_w == data_i);
  assign seeded = poly_sel_i ? (|hist_q) : (|hist_q[6:0]);

  prbs_lock_ctrl #(
    .LOCK_WORDS (LOCK_WORDS),
    .QUAL7      (PASS7_WORDS),
    .QUAL31     (PASS31_WORDS)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .clr_i    (clr_i),
    .valid_i  (valid_i),
    .sel_i    (poly_sel_i),
    .match_i  (match),
    .seeded_i (seeded),
    .reseed_o (reseed),
    .done_o   (locked)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      hist_q <= '0;
      err_o  <= 1'b0;
    end else begin
      err_o <= valid_i && locked && !match;
      if (valid_i) hist_q <= hist_d;
    end
  end

  assign done_o = locked;

endmodule

// File: rtl/prbs_verifier_checker.sv
module prbs_verifier_checker (
  input logic clk_i,
  input logic rst_i,
  input logic valid_i,
  input logic clr_i,
  input logic done_o,
  input logic err_o
);

  assert_err_gated_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |-> done_o);

  assert_err_needs_word_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |-> $past(valid_i));

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!valid_i && !clr_i) |=> ($stable(done_o) && !err_o));

  assert_clr_drop_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> (!done_o && !err_o));

  assert_done_rise_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(done_o) |-> ($past(valid_i) && !$past(clr_i)));

endmodule

bind prbs_verifier prbs_verifier_checker u_chk (.*);

// File: tb/prbs_verifier_tb.sv
module prbs_verifier_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int LOCK_W     = 4;
  localparam int PASS31     = 64;
  localparam int PASS7      = (127 + DATA_W - 1) / DATA_W;
  localparam int N7         = 1 + LOCK_W + PASS7;
  localparam int N31        = 1 + LOCK_W + PASS31;

  logic              clk_i = 1'b0;
  logic              rst_i = 1'b1;
  logic [DATA_W-1:0] data_i = '0;
  logic              valid_i = 1'b0;
  logic              poly_sel_i = 1'b0;
  logic              clr_i = 1'b0;
  logic              done_o;
  logic              err_o;

  int checks = 0;
  int errors = 0;
  logic [30:0] gh;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prbs_verifier #(.DATA_W(DATA_W), .LOCK_WORDS(LOCK_W), .PASS31_WORDS(PASS31)) u_dut (
    .clk_i(clk_i), .rst_i(rst_i), .data_i(data_i), .valid_i(valid_i),
    .poly_sel_i(poly_sel_i), .clr_i(clr_i), .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] gen_word(input logic sel);
    logic [DATA_W-1:0] w;
    logic b;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      b    = sel ? (gh[30] ^ gh[27]) : (gh[6] ^ gh[5]);
      w[i] = b;
      gh   = {gh[29:0], b};
    end
    return w;
  endfunction

  task automatic drive(input logic [DATA_W-1:0] d, input logic v, input logic c);
    @(negedge clk_i);
    data_i  = d;
    valid_i = v;
    clr_i   = c;
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_clear();
    drive($urandom(), 1'b0, 1'b1);
    check("R9 done after clear", done_o, 0);
    check("R9 err after clear", err_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] w;
    logic [DATA_W-1:0] m;
    logic bad;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 done in reset", done_o, 0);
    check("R1 err in reset", err_o, 0);
    @(negedge clk_i); rst_i = 1'b0;
    @(posedge clk_i); #1;
    check("R1 done after reset", done_o, 0);
    check("R1 err after reset", err_o, 0);

    // R2 R3 R4 R8: 7-stage lock timing with idle gaps
    poly_sel_i = 1'b0;
    gh = 31'h0000_0051;
    do_clear();
    for (int k = 1; k <= N7 + 3; k++) begin
      drive(gen_word(1'b0), 1'b1, 1'b0);
      check("R4 done timing prbs7", done_o, (k >= N7));
      check("R5 err quiet while clean", err_o, 0);
      if (k == 3) begin
        for (int g = 0; g < 3; g++) begin
          drive($urandom(), 1'b0, 1'b0);
          check("R8 idle no done", done_o, 0);
          check("R8 idle no err", err_o, 0);
        end
      end
    end

    // R5 R6 R7: random corruption after lock
    for (int k = 0; k < 60; k++) begin
      w   = gen_word(1'b0);
      bad = ($urandom_range(0, 3) == 0) || (k == 10) || (k == 11);
      m   = '0;
      if (bad) begin
        m = (k == 10) ? '1 : (k == 11) ? 32'h0000_0100 : DATA_W'($urandom());
        if (m == '0) m = 32'h8000_0000;
      end
      drive(w ^ m, 1'b1, 1'b0);
      check("R6 one pulse per bad word", err_o, bad);
      check("R7 done held with errors", done_o, 1);
      if (k == 20) begin
        drive($urandom(), 1'b0, 1'b0);
        check("R8 idle while locked err", err_o, 0);
        check("R8 idle while locked done", done_o, 1);
      end
    end

    // R9: clear together with a corrupted word
    w = gen_word(1'b0);
    drive(~w, 1'b1, 1'b1);
    check("R9 clear beats error", err_o, 0);
    check("R9 clear drops done", done_o, 0);
    for (int k = 1; k <= N7; k++) begin
      drive(gen_word(1'b0), 1'b1, 1'b0);
      check("R9 realign timing", done_o, (k >= N7));
    end

    // R4: mismatch during qualification restarts alignment
    do_clear();
    for (int k = 1; k <= 16; k++) begin
      w = gen_word(1'b0);
      if (k == LOCK_W + 2) w = w ^ 32'h0001_0000;
      drive(w, 1'b1, 1'b0);
      check("R4 qual restart timing", done_o, (k >= LOCK_W + 2 + LOCK_W + PASS7));
      check("R5 no err before done", err_o, 0);
    end

    // R2: 31-stage sequence
    poly_sel_i = 1'b1;
    gh = 31'h5A5A_1234;
    do_clear();
    for (int k = 1; k <= N31 + 2; k++) begin
      drive(gen_word(1'b1), 1'b1, 1'b0);
      check("R2 done timing prbs31", done_o, (k >= N31));
    end
    for (int k = 0; k < 20; k++) begin
      bad = (k % 5 == 2);
      w = gen_word(1'b1);
      drive(bad ? (w ^ 32'h0000_0003) : w, 1'b1, 1'b0);
      check("R2 prbs31 error detect", err_o, bad);
    end

    // R10: all-zero stream
    do_clear();
    for (int k = 0; k < 30; k++) begin
      drive('0, 1'b1, 1'b0);
      check("R10 zero stream no lock", done_o, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule